// File: doc/BRIEF.md
# Interleaved Sample Deinterleaver

This block takes one stream of signed 16-bit samples in which the channels take turns: the first sample of every channel in channel order, then the second sample of every channel, and so on. It sorts each accepted word into its channel slot and presents the channels side by side on one wide output bus, one 16-bit lane per channel. The number of channels is a parameter, 10 by default, and any value from 3 to 15 is allowed.

A slot counter moves forward on each valid word. The first N-1 words of a frame wait in a shadow bank. When the final word of the frame arrives, every output lane is loaded on the same clock edge and a one-cycle frame strobe is raised. Downstream logic therefore never sees lanes that come from two different sample instants.

Top module: `chan_deinterleave`

## Requirements
- R1: The k-th accepted word of a frame (k = 0 .. N-1) appears on lane k. Lane k occupies bits [16k+15 : 16k] of `frame_data`.
- R2: The slot counter advances by one for each accepted word only, and wraps from N-1 back to 0. After N accepted words the next word is taken as lane 0 of a new frame.
- R3: `frame_valid` is high for exactly one cycle, in the cycle after the clock edge that accepts the final word of a frame. It is low at all other times.
- R4: All lanes of `frame_data` change together, on the edge that accepts the final word. Between those edges they hold their values, including while a frame is partly assembled.
- R5: When `in_valid` is low, `in_data` is ignored and the slot position does not move. Idle gaps between words leave the assembled frame unchanged.
- R6: Reset clears `frame_data` to zero and `frame_valid` to low, and returns the slot counter to 0, so the first valid word after reset is lane 0.
- R7: Samples are signed two's-complement values and pass through bit for bit unchanged, including 0x8000, 0x7FFF and 0xFFFF.
- R8: A partial frame that is cut short by reset is dropped. The lanes stay zero until a complete new frame has arrived.
- R9: When words arrive on every cycle, frames complete every N cycles and `frame_valid` pulses once per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 16 | Incoming interleaved sample |
| in_valid | input | 1 | High when `in_data` carries a sample |
| frame_data | output | 16*N | All lanes, lane k in bits [16k+15:16k] |
| frame_valid | output | 1 | One-cycle strobe when a new frame is on `frame_data` |

## Verification
Words are accepted on one clock edge, and the only registered outputs sit one stage after that edge. A completed frame and its `frame_valid` strobe are therefore due in the cycle that follows the final word. The bench drives every word on a falling edge and reads the outputs on the next falling edge. At that point it expects either the new frame with the strobe high, or, for any word before the last, the previous lanes unchanged with the strobe low. It reads again one falling edge later to confirm that the strobe has dropped after a single cycle.

// File: rtl/dilv_pkg.sv
package dilv_pkg;
    localparam int DEF_SAMPLE_W = 16;
    localparam int DEF_NUM_CH   = 10;
    localparam int MIN_NUM_CH   = 3;
    localparam int MAX_NUM_CH   = 15;
endpackage

// File: rtl/dilv_slot_counter.sv
module dilv_slot_counter #(
    parameter int NUM_CH = dilv_pkg::DEF_NUM_CH,
    localparam int SLOT_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic              last_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CH - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step_i) begin
            if (cnt_q.slot == LAST_SLOT) cnt_d.slot = '0;
            else                         cnt_d.slot = cnt_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign slot_o = cnt_q.slot;
    assign last_o = (cnt_q.slot == LAST_SLOT);

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_o <= LAST_SLOT); // R2
    AST_SLOT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(slot_o)); // R5
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && last_o) |=> (slot_o == '0)); // R2
endmodule

// File: rtl/dilv_shadow_bank.sv
module dilv_shadow_bank #(
    parameter int NUM_CH   = dilv_pkg::DEF_NUM_CH,
    parameter int SAMPLE_W = dilv_pkg::DEF_SAMPLE_W,
    localparam int SLOT_W  = $clog2(NUM_CH),
    localparam int HELD    = NUM_CH - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [SLOT_W-1:0]        slot_i,
    input  logic [SAMPLE_W-1:0]      data_i,
    output logic [HELD*SAMPLE_W-1:0] bank_o
);
    typedef struct packed {
        logic [HELD-1:0][SAMPLE_W-1:0] word;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < HELD; i++) begin
            if (wr_en_i && (slot_i == SLOT_W'(i))) bank_d.word[i] = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign bank_o = bank_q.word;

    AST_SHADOW_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(bank_o)); // R5
endmodule

// File: rtl/dilv_frame_reg.sv
module dilv_frame_reg #(
    parameter int NUM_CH   = dilv_pkg::DEF_NUM_CH,
    parameter int SAMPLE_W = dilv_pkg::DEF_SAMPLE_W,
    localparam int HELD    = NUM_CH - 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic [HELD*SAMPLE_W-1:0]   bank_i,
    input  logic [SAMPLE_W-1:0]        tail_i,
    output logic [NUM_CH*SAMPLE_W-1:0] frame_o,
    output logic                       valid_o
);
    typedef struct packed {
        logic [NUM_CH*SAMPLE_W-1:0] frame;
        logic                       valid;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = load_i;
        if (load_i) out_d.frame = {tail_i, bank_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign frame_o = out_q.frame;
    assign valid_o = out_q.valid;
endmodule

// File: rtl/chan_deinterleave.sv
module chan_deinterleave #(
    parameter int NUM_CH   = dilv_pkg::DEF_NUM_CH,
    parameter int SAMPLE_W = dilv_pkg::DEF_SAMPLE_W,
    localparam int SLOT_W  = $clog2(NUM_CH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SAMPLE_W-1:0]        in_data,
    input  logic                       in_valid,
    output logic [NUM_CH*SAMPLE_W-1:0] frame_data,
    output logic                       frame_valid
);
    logic [SLOT_W-1:0]              slot;
    logic                           at_last;
    logic [(NUM_CH-1)*SAMPLE_W-1:0] bank;
    logic                           load;

    assign load = in_valid && at_last;

    dilv_slot_counter #(.NUM_CH(NUM_CH)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (in_valid),
        .slot_o (slot),
        .last_o (at_last)
    );

    dilv_shadow_bank #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (in_valid),
        .slot_i  (slot),
        .data_i  (in_data),
        .bank_o  (bank)
    );

    dilv_frame_reg #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .bank_i  (bank),
        .tail_i  (in_data),
        .frame_o (frame_data),
        .valid_o (frame_valid)
    );

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> $past(in_valid && at_last)); // R3
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid); // R3
    AST_LANES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> $stable(frame_data)); // R4
    AST_TAIL_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (frame_data[NUM_CH*SAMPLE_W-1 -: SAMPLE_W] == $past(in_data))); // R1
endmodule

// File: tb/chan_deinterleave_test.sv
module chan_deinterleave_test;
    localparam int N = 10;
    localparam int W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [W-1:0]     in_data = '0;
    logic             in_valid = 1'b0;
    logic [N*W-1:0]   frame_data;
    logic             frame_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [W-1:0] expv [N];

    always #10 clk = ~clk;

    chan_deinterleave #(.NUM_CH(N), .SAMPLE_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .frame_data(frame_data), .frame_valid(frame_valid)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic chk_lanes(input string req);
        for (int c = 0; c < N; c++) chk(req, frame_data[c*W +: W], expv[c]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < N; c++) expv[c] = '0;
    endtask

    // Send one frame; gap inserts idle cycles carrying junk data after each word.
    task automatic t_frame(input string req, input logic [W-1:0] base, input int gap, input bit signed_set);
        logic [W-1:0] w [N];
        for (int c = 0; c < N; c++) begin
            if (signed_set) w[c] = (c % 3 == 0) ? 16'h8000 : (c % 3 == 1) ? 16'h7FFF : 16'hFFFF;
            else            w[c] = base + W'(c * 16'h0111);
        end
        for (int c = 0; c < N; c++) begin
            in_data = w[c];
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            if (c < N - 1) begin
                chk({req, " R4 no pulse mid-frame"}, {15'd0, frame_valid}, 16'd0);
                chk_lanes({req, " R4 lanes hold mid-frame"});
                for (int g = 0; g < gap; g++) begin
                    in_data = 16'hDEAD;
                    @(negedge clk);
                    chk({req, " R5 idle ignored"}, {15'd0, frame_valid}, 16'd0);
                end
            end
        end
        for (int c = 0; c < N; c++) expv[c] = w[c];
        chk({req, " R3 pulse after last word"}, {15'd0, frame_valid}, 16'd1);
        chk_lanes({req, " R1 lane order"});
        @(negedge clk);
        chk({req, " R3 pulse one cycle"}, {15'd0, frame_valid}, 16'd0);
        chk_lanes({req, " R4 lanes hold after frame"});
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R6 reset strobe", {15'd0, frame_valid}, 16'd0);
        chk_lanes("R6 reset lanes");
    endtask

    task automatic t_back_to_back();
        int pulses = 0;
        for (int f = 0; f < 2; f++) begin
            for (int c = 0; c < N; c++) begin
                in_data = W'(16'h4000 + f * 16'h0100 + c);
                in_valid = 1'b1;
                @(negedge clk);
                if (frame_valid) pulses++;
            end
        end
        in_valid = 1'b0;
        for (int c = 0; c < N; c++) expv[c] = W'(16'h4100 + c);
        chk("R9 pulse on last word", {15'd0, frame_valid}, 16'd1);
        chk_lanes("R9 second frame lanes");
        chk("R9 pulse count", W'(pulses), 16'd2);
        @(negedge clk);
        chk("R9 strobe drops", {15'd0, frame_valid}, 16'd0);
    endtask

    task automatic t_mid_reset();
        for (int c = 0; c < 4; c++) begin
            in_data = W'(16'h0AA0 + c);
            in_valid = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        do_reset();
        chk_lanes("R8 partial dropped");
        t_frame("R8 R2 realign", 16'h2000, 0, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_frame("R1", 16'h1000, 0, 1'b0);
        t_frame("R5 gaps", 16'h3000, 2, 1'b0);
        t_frame("R7 signed", 16'h0000, 0, 1'b1);
        t_frame("R2 wrap", 16'h5000, 0, 1'b0);
        t_back_to_back();
        t_mid_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule